// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of virtual-to-physical address translations. Every cached translation carries the address-space identifier of the process that owns it, a global flag, a page-size code and three access rights: write-protected, no-execute and supervisor-only. A lookup presents a virtual address, the current address-space identifier, the access kind and the privilege mode. In the same cycle the block reports a hit or a miss and gives either the physical address or a permission fault. A miss is only reported. Servicing it is left to an external table walker, which later installs the translation through the fill port.

Three page sizes share one array: 4 KB, 64 KB and 1 MB. Only the tag bits above each entry's own page offset are compared, so one entry covers a whole large page or section. Two clear operations exist. One clears the whole array. The other clears by identifier and leaves global entries in place, so supervisor mappings survive a context switch. A fill picks the lowest-numbered free slot. When no slot is free it picks a round-robin victim.

Top module: `vtrans_buffer`

## Requirements
- R1: A lookup hits when an entry is valid, its virtual tag matches above that entry's page offset (size code 0 = 4 KB, 1 = 64 KB, 2 = 1 MB), and the entry is global or its identifier equals `lk_asid`. The result is combinational in the same cycle. `lk_paddr` is the entry's physical bits above the offset joined with the lookup address's offset bits.
- R2: When no entry matches, `lk_hit`, `lk_fault` and `lk_paddr` are all zero.
- R3: On a hit, a store (`lk_kind` = 1) to a write-protected entry faults, and an instruction fetch (`lk_kind` = 2) to a no-execute entry faults. A load has `lk_kind` = 0. When a fault is raised, `lk_hit` = 1, `lk_fault` = 1 and `lk_paddr` = 0.
- R4: On a hit, a user-mode access (`lk_user` = 1) faults when the entry is supervisor-only or when the address lies in 0xC000_0000..0xFFFF_FFFF.
- R5: Clear-by-identifier removes every non-global entry whose identifier equals `inv_asid`. Global entries and entries with other identifiers stay.
- R6: Clear-all removes every entry, global ones included, at one clock edge.
- R7: When a clear and a fill arrive in the same cycle, the clear is applied first and then the fill, so the filled translation is present afterwards.
- R8: A fill goes to the lowest-numbered invalid slot. When every slot is valid it goes to a round-robin pointer. The pointer starts at 0, advances by one only on such fills, and wraps.
- R9: After reset no entry is valid and the round-robin pointer is 0.
- R10: A filled translation takes part in lookups from the first rising edge after the fill is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_hit | output | 1 | A translation was found |
| lk_fault | output | 1 | The hit violates the entry's rights |
| lk_paddr | output | 32 | Physical address, zero on miss or fault |
| fill_en | input | 1 | Install a translation |
| fill_vaddr | input | 32 | Virtual base of the new page |
| fill_paddr | input | 32 | Physical base of the new page |
| fill_asid | input | 8 | Owner identifier |
| fill_size | input | 2 | Page-size code |
| fill_global | input | 1 | Entry matches any identifier |
| fill_ro | input | 1 | Write-protected |
| fill_nx | input | 1 | No-execute |
| fill_kern | input | 1 | Supervisor-only |
| inv_all | input | 1 | Clear every entry |
| inv_asid_en | input | 1 | Clear the non-global entries of one identifier |
| inv_asid | input | 8 | Identifier to clear |

## Verification
Lookup results are combinational, so hit, fault and address are due in the same cycle as the lookup inputs. The bench drives each lookup at a falling edge and samples it 2 ns later, before the next rising edge. Fills and clears change the array at the next rising edge. The bench therefore checks their effect at least one falling edge later, and checks once before that edge that a fresh fill is not yet visible. Which slot receives a fill is inferred only from which translation disappears from lookups.

// File: rtl/vtb_pkg.sv
package vtb_pkg;
  localparam int VA_W  = 32;
  localparam int PG_SH = 12;
  localparam int PN_W  = VA_W - PG_SH;

  typedef enum logic [1:0] {
    PG_SMALL   = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SECTION = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic [PN_W-1:0] vpn;
    logic [PN_W-1:0] ppn;
    pg_size_e        size;
    logic            glob;
    logic            ro;
    logic            nx;
    logic            kern;
  } xlat_t;

  // Offset bits of a page of the given size; size code 3 is treated as small.
  function automatic logic [VA_W-1:0] off_mask(pg_size_e s);
    case (s)
      PG_LARGE:   return 32'h0000_FFFF;
      PG_SECTION: return 32'h000F_FFFF;
      default:    return 32'h0000_0FFF;
    endcase
  endfunction
endpackage

// File: rtl/vtb_match.sv
module vtb_match import vtb_pkg::*; #(
  parameter int ASID_W = 8
) (
  input  logic              valid_i,
  input  xlat_t             ent_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              hit_o,
  output logic [VA_W-1:0]   pa_o
);
  logic [VA_W-1:0] m;
  logic [VA_W-1:0] ent_tag;

  always_comb begin
    m       = off_mask(ent_i.size);
    ent_tag = {ent_i.vpn, {PG_SH{1'b0}}} & ~m;
    hit_o   = valid_i && (ent_tag == (va_i & ~m)) &&
              (ent_i.glob || (ent_asid_i == cur_asid_i));
    pa_o    = ({ent_i.ppn, {PG_SH{1'b0}}} & ~m) | (va_i & m);
  end
endmodule

// File: rtl/vtb_store.sv
module vtb_store import vtb_pkg::*; #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             inv_all_i,
  input  logic                             inv_asid_en_i,
  input  logic [ASID_W-1:0]                inv_asid_i,
  input  logic                             fill_en_i,
  input  xlat_t                            fill_ent_i,
  input  logic [ASID_W-1:0]                fill_asid_i,
  input  logic [IDX_W-1:0]                 fill_idx_i,
  output logic [ENTRIES-1:0]               valid_o,
  output logic [ENTRIES-1:0]               keep_o,
  output xlat_t [ENTRIES-1:0]              ent_o,
  output logic [ENTRIES-1:0][ASID_W-1:0]   asid_o
);
  logic [ENTRIES-1:0]             valid_q;
  xlat_t [ENTRIES-1:0]            ent_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0]             glob_v;

  // Clear is resolved first; the fill then writes over the surviving set.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      glob_v[i] = ent_q[i].glob;
      keep_o[i] = valid_q[i] && !(inv_all_i ||
                  (inv_asid_en_i && !ent_q[i].glob && asid_q[i] == inv_asid_i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      valid_q <= keep_o;
      if (fill_en_i) valid_q[fill_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en_i) begin
      ent_q[fill_idx_i]  <= fill_ent_i;
      asid_q[fill_idx_i] <= fill_asid_i;
    end
  end

  assign valid_o = valid_q;
  assign ent_o   = ent_q;
  assign asid_o  = asid_q;

  assert_flush_all_R6: assert property (@(posedge clk) disable iff (rst)
    inv_all_i && !fill_en_i |=> valid_q == '0);

  assert_global_survives_R5: assert property (@(posedge clk) disable iff (rst)
    inv_asid_en_i && !inv_all_i && !fill_en_i |=>
      (valid_q & glob_v) == $past(valid_q & glob_v));

  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (rst)
    fill_en_i |=> valid_q[$past(fill_idx_i)]);
endmodule

// File: rtl/vtb_victim.sv
module vtb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] keep_i,
  input  logic               fill_en_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] first_free;
  logic             any_free;

  always_comb begin
    any_free   = 1'b0;
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!keep_i[i]) begin
        any_free   = 1'b1;
        first_free = IDX_W'(i);
      end
    end
    idx_o = any_free ? first_free : rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_en_i && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  assert_free_first_R8: assert property (@(posedge clk) disable iff (rst)
    fill_en_i && (keep_i != '1) |-> !keep_i[idx_o]);

  assert_rr_moves_R8: assert property (@(posedge clk) disable iff (rst)
    fill_en_i && (keep_i == '1) |=> rr_q != $past(rr_q));

  assert_rr_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !fill_en_i |=> $stable(rr_q));
endmodule

// File: rtl/vtrans_buffer.sv
module vtrans_buffer import vtb_pkg::*; #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_kind,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [31:0]       lk_paddr,
  input  logic              fill_en,
  input  logic [31:0]       fill_vaddr,
  input  logic [31:0]       fill_paddr,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [1:0]        fill_size,
  input  logic              fill_global,
  input  logic              fill_ro,
  input  logic              fill_nx,
  input  logic              fill_kern,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic [ASID_W-1:0] inv_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  xlat_t                          fill_ent;
  logic [IDX_W-1:0]               victim;
  logic [ENTRIES-1:0]             valid_v;
  logic [ENTRIES-1:0]             keep_v;
  xlat_t [ENTRIES-1:0]            ent_v;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_v;
  logic [ENTRIES-1:0]             hit_v;
  logic [ENTRIES-1:0][VA_W-1:0]   pa_v;
  logic [IDX_W-1:0]               sel;
  logic                           any_hit;
  logic                           viol;

  always_comb begin
    fill_ent.vpn  = fill_vaddr[VA_W-1:PG_SH];
    fill_ent.ppn  = fill_paddr[VA_W-1:PG_SH];
    fill_ent.size = pg_size_e'(fill_size);
    fill_ent.glob = fill_global;
    fill_ent.ro   = fill_ro;
    fill_ent.nx   = fill_nx;
    fill_ent.kern = fill_kern;
  end

  vtb_store #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .inv_all_i(inv_all), .inv_asid_en_i(inv_asid_en), .inv_asid_i(inv_asid),
    .fill_en_i(fill_en), .fill_ent_i(fill_ent), .fill_asid_i(fill_asid),
    .fill_idx_i(victim),
    .valid_o(valid_v), .keep_o(keep_v), .ent_o(ent_v), .asid_o(asid_v)
  );

  vtb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .keep_i(keep_v), .fill_en_i(fill_en), .idx_o(victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    vtb_match #(.ASID_W(ASID_W)) u_match (
      .valid_i(valid_v[g]), .ent_i(ent_v[g]), .ent_asid_i(asid_v[g]),
      .va_i(lk_vaddr), .cur_asid_i(lk_asid),
      .hit_o(hit_v[g]), .pa_o(pa_v[g])
    );
  end

  // Lowest-numbered matching slot wins if overlapping fills left duplicates.
  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        any_hit = 1'b1;
        sel     = IDX_W'(i);
      end
    end
    viol = (lk_kind == ACC_STORE && ent_v[sel].ro) ||
           (lk_kind == ACC_FETCH && ent_v[sel].nx) ||
           (lk_user && (ent_v[sel].kern || lk_vaddr[VA_W-1 -: 2] == 2'b11));
    lk_hit   = any_hit;
    lk_fault = any_hit && viol;
    lk_paddr = (any_hit && !viol) ? pa_v[sel] : '0;
  end

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_fault && lk_paddr == '0);

  assert_user_kernel_region_R4: assert property (@(posedge clk) disable iff (rst)
    lk_hit && lk_user && lk_vaddr[31:30] == 2'b11 |-> lk_fault);
endmodule

// File: tb/vtrans_buffer_test.sv
module vtrans_buffer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_user = 1'b0;
  logic        lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [31:0] fill_vaddr = '0, fill_paddr = '0;
  logic [7:0]  fill_asid = '0;
  logic [1:0]  fill_size = '0;
  logic        fill_global = 1'b0, fill_ro = 1'b0, fill_nx = 1'b0, fill_kern = 1'b0;
  logic        inv_all = 1'b0, inv_asid_en = 1'b0;
  logic [7:0]  inv_asid = '0;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vtrans_buffer uut (
    .clk(clk), .rst(rst),
    .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_kind(lk_kind), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
    .fill_asid(fill_asid), .fill_size(fill_size), .fill_global(fill_global),
    .fill_ro(fill_ro), .fill_nx(fill_nx), .fill_kern(fill_kern),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
  );

  // {vaddr, asid, kind, user, hit, fault, paddr, requirement}
  localparam int NV = 13;
  localparam logic [80:0] VEC [NV] = '{
    {32'h0040_1ABC, 8'd5, 2'd0, 1'b1, 1'b1, 1'b0, 32'h8000_5ABC, 4'd1}, // R1 small, asid 5
    {32'h0040_1ABC, 8'd7, 2'd0, 1'b1, 1'b1, 1'b0, 32'h7000_0ABC, 4'd1}, // R1 same page, asid 7
    {32'h0040_1ABC, 8'd9, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 4'd2}, // R2 foreign asid
    {32'h0012_F123, 8'd5, 2'd0, 1'b1, 1'b1, 1'b0, 32'h9ABC_F123, 4'd1}, // R1 64 KB page
    {32'h0012_0004, 8'd5, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd3}, // R3 store to ro
    {32'h0012_0004, 8'd5, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd3}, // R3 fetch to nx
    {32'hC01A_BCDE, 8'd9, 2'd0, 1'b0, 1'b1, 1'b0, 32'h001A_BCDE, 4'd1}, // R1 global section
    {32'hC01A_BCDE, 8'd9, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd4}, // R4 user on kern entry
    {32'h0013_0000, 8'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 4'd2}, // R2 past 64 KB end
    {32'h0050_0FFF, 8'd3, 2'd1, 1'b1, 1'b1, 1'b0, 32'h6600_0FFF, 4'd1}, // R1 global user store
    {32'h0040_2000, 8'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 4'd2}, // R2 next small page
    {32'hD000_0010, 8'd5, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd4}, // R4 user in kernel region
    {32'hD000_0010, 8'd5, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0ABC_D010, 4'd4}  // R4 supervisor allowed
  };

  task automatic check(input string req, input logic eh, input logic ef, input logic [31:0] ep);
    total++;
    if (lk_hit !== eh || lk_fault !== ef || lk_paddr !== ep) begin
      fails++;
      $display("FAIL %s: hit=%0b fault=%0b pa=%h expected hit=%0b fault=%0b pa=%h",
               req, lk_hit, lk_fault, lk_paddr, eh, ef, ep);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] as, input logic [1:0] k,
                      input logic u, input logic eh, input logic ef, input logic [31:0] ep,
                      input string req);
    @(negedge clk);
    lk_vaddr = va; lk_asid = as; lk_kind = k; lk_user = u;
    #2;
    check(req, eh, ef, ep);
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [7:0] as,
                      input logic [1:0] sz, input logic g, input logic ro, input logic nx,
                      input logic kn);
    @(negedge clk);
    fill_en = 1'b1; fill_vaddr = va; fill_paddr = pa; fill_asid = as; fill_size = sz;
    fill_global = g; fill_ro = ro; fill_nx = nx; fill_kern = kn;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic flush_all();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
  endtask

  task automatic flush_asid(input logic [7:0] as);
    @(negedge clk); inv_asid_en = 1'b1; inv_asid = as;
    @(negedge clk); inv_asid_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: nothing valid after reset
    look(32'h0040_1000, 8'd5, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, "R9 empty after reset");

    fill(32'h0040_1000, 32'h8000_5000, 8'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); // A
    fill(32'h0012_0000, 32'h9ABC_0000, 8'd5, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0); // B
    fill(32'hC010_0000, 32'h0010_0000, 8'd5, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1); // C
    fill(32'h0040_1000, 32'h7000_0000, 8'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); // D
    fill(32'h0050_0000, 32'h6600_0000, 8'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); // E
    fill(32'hD000_0000, 32'h0ABC_D000, 8'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); // F

    for (int i = 0; i < NV; i++) begin
      logic [80:0] v;
      v = VEC[i];
      @(negedge clk);
      lk_vaddr = v[80:49]; lk_asid = v[48:41]; lk_kind = v[40:39]; lk_user = v[38];
      #2;
      check($sformatf("R%0d vector %0d", v[3:0], i), v[37], v[36], v[35:4]);
    end

    // R10: a fill is not visible before its edge, visible after it
    @(negedge clk);
    fill_en = 1'b1; fill_vaddr = 32'h0600_0000; fill_paddr = 32'h0660_0000; fill_asid = 8'd5;
    fill_size = 2'd0; fill_global = 1'b0; fill_ro = 1'b0; fill_nx = 1'b0; fill_kern = 1'b0;
    lk_vaddr = 32'h0600_0040; lk_asid = 8'd5; lk_kind = 2'd0; lk_user = 1'b1;
    #2;
    check("R10 before edge", 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    fill_en = 1'b0;
    #2;
    check("R10 after edge", 1'b1, 1'b0, 32'h0660_0040);

    // R5: clear asid 5 keeps globals and other asids
    flush_asid(8'd5);
    look(32'h0040_1000, 8'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R5 A cleared");
    look(32'h0012_0000, 8'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R5 B cleared");
    look(32'h0040_1004, 8'd7, 2'd0, 1'b1, 1'b1, 1'b0, 32'h7000_0004, "R5 other asid kept");
    look(32'hC010_0008, 8'd5, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0010_0008, "R5 global section kept");
    look(32'h0050_0010, 8'd5, 2'd0, 1'b1, 1'b1, 1'b0, 32'h6600_0010, "R5 global page kept");

    // R6: clear-all drops everything, global included
    flush_all();
    look(32'hC010_0008, 8'd5, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, "R6 global cleared");
    look(32'h0050_0010, 8'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R6 global page cleared");
    look(32'h0040_1004, 8'd7, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R6 asid 7 cleared");

    // R7: clear-all and fill in one cycle
    fill(32'h0700_0000, 32'h0770_0000, 8'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    inv_all = 1'b1; fill_en = 1'b1; fill_vaddr = 32'h0800_0000; fill_paddr = 32'h0880_0000;
    fill_asid = 8'd1; fill_size = 2'd0; fill_global = 1'b0;
    @(negedge clk);
    inv_all = 1'b0; fill_en = 1'b0;
    look(32'h0700_0000, 8'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R7 old entry cleared");
    look(32'h0800_0123, 8'd1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0880_0123, "R7 fill survives");

    // R8: fill order, round robin and free-slot preference
    flush_all();
    for (int i = 0; i < 16; i++)
      fill(32'h0100_0000 + (i << 12), 32'h4000_0000 + (i << 12), (i == 5) ? 8'd2 : 8'd1,
           2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    look(32'h0100_0000, 8'd1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h4000_0000, "R8 slot 0 filled");
    fill(32'h0200_0000, 32'h5000_0000, 8'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    look(32'h0100_0000, 8'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R8 first victim slot 0");
    look(32'h0200_0000, 8'd1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h5000_0000, "R8 new page present");
    fill(32'h0210_0000, 32'h5100_0000, 8'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    look(32'h0100_1000, 8'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R8 second victim slot 1");
    flush_asid(8'd2);
    fill(32'h0220_0000, 32'h5200_0000, 8'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    look(32'h0100_2000, 8'd1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h4000_2000, "R8 free slot preferred");
    look(32'h0220_0000, 8'd1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h5200_0000, "R8 free slot filled");
    fill(32'h0230_0000, 32'h5300_0000, 8'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    look(32'h0100_2000, 8'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R8 pointer resumes at slot 2");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule